// File: doc/BRIEF.md
# Xorshift Generator with Mixed Output Word

This block is a repeatable pseudo-random word source with a single 32-bit state register. Each enabled cycle advances the state by one xorshift step: a left shift by 13 XORed in, then a right shift by 17 XORed in, then a left shift by 5 XORed in. In the same cycle it emits one full output word. That word is formed by running the state from before the step through a nonlinear mix of rotates and modulo-2^32 additions, then XORing the result with the state from after the step. A single step yields a whole output word, so the state is never advanced twice to build one result.

Software or a surrounding datapath seeds the generator through a load strobe and a seed value. A seed of zero would lock the xorshift recurrence at zero, so it is replaced by 1. The output word is registered. A valid flag marks the cycle after each step, and the word holds its value while no step is requested. Reset is asserted asynchronously and released on the clock through a two-stage synchronizer.

Top module: `prng_xs_hashed`

## Requirements
- R1: After reset the state is 1, `rnd_vld` is 0 and `rnd_o` is 0; the first step after reset therefore yields 0x220028A0.
- R2: A step replaces state s in this order: s ^= s<<13, then s ^= s>>17, then s ^= s<<5, with all shifts logical and the result kept to 32 bits.
- R3: The output of a step taken from state t is h XOR n. Here n is the state after the step. h is formed from t in two stages: first t1 = t + rotl(t,18), then h = t1 + (rotl(t1,7) XOR rotl(t1,11)). rotl is a left rotate within 32 bits, and every addition is modulo 2^32.
- R4: `step_en` high with `seed_wr` low in cycle k makes `rnd_o` carry that step's word and `rnd_vld` read 1 after clock edge k, one cycle later. Steps on consecutive cycles give one word per cycle.
- R5: `seed_wr` high loads `seed_val` into the state. A seed of 0 loads 1 instead.
- R6: When `seed_wr` and `step_en` are both high, the load wins. No step is taken, `rnd_vld` reads 0 in the next cycle and `rnd_o` keeps its value.
- R7: With both strobes low the state and `rnd_o` keep their values and `rnd_vld` reads 0. The next step continues from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Advance the generator by one step and produce a word |
| seed_wr | input | 1 | Load `seed_val` into the state (has priority over `step_en`) |
| seed_val | input | 32 | Seed value; 0 is replaced by 1 |
| rnd_o | output | 32 | Registered output word |
| rnd_vld | output | 1 | High in the cycle after a step |

## Verification
The bench builds the block with its default parameters: a 32-bit word, shifts of 13, 17 and 5, and rotates of 18, 7 and 11. These are the values its own reference recurrence uses, so every output word can be compared bit for bit. A fixed first word after reset and several hundred back-to-back steps exercise the carries of the modulo additions across many states. Seeds of zero and all-ones, a load that collides with a step, and idle gaps cover the priority and hold rules.

// File: rtl/prng_xs_pkg.sv
package prng_xs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } prng_op_e;
endpackage

// File: rtl/prng_rst_sync.sv
module prng_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/prng_xs_core.sv
module prng_xs_core
  import prng_xs_pkg::*;
#(
  parameter int W    = 32,
  parameter int SH_A = 13,
  parameter int SH_B = 17,
  parameter int SH_C = 5
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  prng_op_e     op_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o,
  output logic [W-1:0] post_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] state_q, state_d;
  logic [W-1:0] s1, s2, s3;

  // xorshift step on the current state
  always_comb begin
    s1 = state_q ^ (state_q << SH_A);
    s2 = s1 ^ (s1 >> SH_B);
    s3 = s2 ^ (s2 << SH_C);
  end

  always_comb begin
    state_d = state_q;
    case (op_i)
      OP_STEP: state_d = s3;
      OP_LOAD: state_d = (seed_i == '0) ? ONE : seed_i;
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ONE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign post_o  = s3;

  // R5
  zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == OP_LOAD && seed_i == '0) |=> (state_q == ONE));
  // R5
  state_nz_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    state_q != '0);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == OP_IDLE) |=> $stable(state_q));
endmodule

// File: rtl/prng_mix_out.sv
module prng_mix_out #(
  parameter int W     = 32,
  parameter int ROT_A = 18,
  parameter int ROT_B = 7,
  parameter int ROT_C = 11
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] pre_i,
  input  logic [W-1:0] post_i,
  output logic [W-1:0] word_o,
  output logic         vld_o
);
  logic [W-1:0] t1, t2, mix_d;
  logic [W-1:0] word_q;
  logic         vld_q;

  always_comb begin
    t1    = pre_i + ((pre_i << ROT_A) | (pre_i >> (W - ROT_A)));
    t2    = t1 + (((t1 << ROT_B) | (t1 >> (W - ROT_B))) ^
                  ((t1 << ROT_C) | (t1 >> (W - ROT_C))));
    mix_d = t2 ^ post_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= step_i;
      if (step_i) word_q <= mix_d;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  // R4
  step_vld_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    step_i |=> vld_o);
  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !step_i |=> ($stable(word_o) && !vld_o));
endmodule

// File: rtl/prng_xs_hashed.sv
module prng_xs_hashed
  import prng_xs_pkg::*;
#(
  parameter int W     = 32,
  parameter int SH_A  = 13,
  parameter int SH_B  = 17,
  parameter int SH_C  = 5,
  parameter int ROT_A = 18,
  parameter int ROT_B = 7,
  parameter int ROT_C = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         seed_wr,
  input  logic [W-1:0] seed_val,
  output logic [W-1:0] rnd_o,
  output logic         rnd_vld
);
  logic         rst_sn;
  prng_op_e     op;
  logic [W-1:0] pre_s, post_s;

  prng_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sn));

  // load has priority over step
  always_comb begin
    if (seed_wr)      op = OP_LOAD;
    else if (step_en) op = OP_STEP;
    else              op = OP_IDLE;
  end

  prng_xs_core #(.W(W), .SH_A(SH_A), .SH_B(SH_B), .SH_C(SH_C)) u_core (
    .clk(clk), .rst_ni(rst_sn), .op_i(op), .seed_i(seed_val),
    .state_o(pre_s), .post_o(post_s)
  );

  prng_mix_out #(.W(W), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C)) u_mix (
    .clk(clk), .rst_ni(rst_sn), .step_i(op == OP_STEP),
    .pre_i(pre_s), .post_i(post_s), .word_o(rnd_o), .vld_o(rnd_vld)
  );

  // R6
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (seed_wr && step_en) |=> (!rnd_vld && $stable(rnd_o)));
endmodule

// File: tb/tb_prng_xs_hashed.sv
module tb_prng_xs_hashed;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en, seed_wr;
  logic [31:0] seed_val;
  logic [31:0] rnd_o;
  logic        rnd_vld;

  int checks = 0;
  int failures = 0;
  logic [31:0] ref_s;
  logic [31:0] last_word;

  always #5 clk = ~clk;

  prng_xs_hashed dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .seed_wr(seed_wr),
    .seed_val(seed_val), .rnd_o(rnd_o), .rnd_vld(rnd_vld)
  );

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [31:0] ref_next(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [31:0] ref_word(input logic [31:0] t);
    logic [31:0] a;
    a = t + rl(t, 18);
    a = a + (rl(a, 7) ^ rl(a, 11));
    return a ^ ref_next(t);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // steps n times back to back, checking each word against the model
  task automatic run_steps(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step_en = 1'b1;
      @(negedge clk);
      chk(req, rnd_o, ref_word(ref_s));
      chk({req, " vld"}, {31'd0, rnd_vld}, 32'd1);
      ref_s = ref_next(ref_s);
    end
    step_en = 1'b0;
  endtask

  task automatic load(input logic [31:0] v);
    seed_wr = 1'b1; seed_val = v;
    @(negedge clk);
    seed_wr = 1'b0;
    ref_s = (v == 0) ? 32'd1 : v;
  endtask

  task automatic t_reset;
    chk("R1 word", rnd_o, 32'd0);
    chk("R1 vld", {31'd0, rnd_vld}, 32'd0);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    chk("R1 first word", rnd_o, 32'h220028A0);
    ref_s = ref_next(32'd1);
  endtask

  task automatic t_sequence;
    run_steps(300, "R2 R3 R4 run");
  endtask

  task automatic t_seed;
    load(32'h0);
    chk("R5 zero-seed vld", {31'd0, rnd_vld}, 32'd0);
    run_steps(3, "R5 zero seed");
    load(32'hFFFF_FFFF);
    run_steps(20, "R5 ones seed");
    load(32'h8000_0000);
    run_steps(20, "R3 msb seed carries");
  endtask

  task automatic t_collide;
    last_word = rnd_o;
    seed_wr = 1'b1; step_en = 1'b1; seed_val = 32'h1234_5678;
    @(negedge clk);
    seed_wr = 1'b0; step_en = 1'b0;
    chk("R6 vld", {31'd0, rnd_vld}, 32'd0);
    chk("R6 word held", rnd_o, last_word);
    ref_s = 32'h1234_5678;
    run_steps(4, "R6 after load");
  endtask

  task automatic t_idle;
    last_word = rnd_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 vld", {31'd0, rnd_vld}, 32'd0);
      chk("R7 word held", rnd_o, last_word);
    end
    run_steps(2, "R7 resume");
    step_en = 1'b1; @(negedge clk); step_en = 1'b0;
    chk("R7 gap step", rnd_o, ref_word(ref_s));
    ref_s = ref_next(ref_s);
    @(negedge clk);
    step_en = 1'b1; @(negedge clk); step_en = 1'b0;
    chk("R4 R7 gap step 2", rnd_o, ref_word(ref_s));
    ref_s = ref_next(ref_s);
  endtask

  initial begin
    rst_n = 1'b0; step_en = 1'b0; seed_wr = 1'b0; seed_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sequence();
    t_seed();
    t_collide();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule